// File: doc/BRIEF.md
# Interrupt-Aggregating Peripheral Register Bank

This block is the register face of a byte-wide I/O controller that sits on a 32-bit processor bus. It keeps three interrupt groups, named A, B and F. Each group has a sticky status byte, a writable mask byte, and a request value equal to status AND mask. Any pending request in group A or group B drives the `irq_o` output. Any pending request in group F drives the `fiq_o` output.

The bank also offers four kinds of readback:
- a control byte that mirrors the levels of two serial-bus lines;
- a keyboard receive-data port;
- the low byte and the high byte of four 16-bit counter values.

The counters, the keyboard receiver and the serial-bus engine live outside this block and reach it only as input ports.

Bus accesses take one cycle and are synchronous. Read data is registered and appears one cycle after the access. A byte read returns the selected byte zero-extended. A word read places that byte in bits 23:16 and drives every other bit high. Reading the keyboard port clears the keyboard-ready status bit of group B as a side effect.

Top module: `ioc_regbank`

## Requirements
- R1: While reset is low, and after it is released, `bus_rdata` is 0, `irq_o` and `fiq_o` are 0, and every status and mask byte reads 0.
- R2: A word read (`bus_word`=1) returns the selected byte in bits 23:16, with bits 31:24 and 15:0 all 1. The data appears on `bus_rdata` after the clock edge that samples the access.
- R3: A byte read (`bus_word`=0) returns the selected byte in bits 7:0, with bits 31:8 zero.
- R4: A read at offset 0x00 returns the stored control byte with bits 7:6 forced to 1. Bit 1 is forced to 0 while `sclk_lvl` is 1, and bit 0 is forced to 0 while `sdat_lvl` is 1. A write at 0x00 stores `bus_wdata[7:0]` as the control byte.
- R5: A 1 on any bit of `set_a`, `set_b` or `set_f` during a clock edge sets that status bit, and the bit stays set. The status bytes read at 0x10 (A), 0x20 (B) and 0x30 (F).
- R6: A write at 0x18, 0x28 or 0x38 loads `bus_wdata[7:0]` into the mask of A, B or F; the masks read back at those same offsets. Reads at 0x14, 0x24 and 0x34 return status AND mask for A, B and F.
- R7: `irq_o` is 1 exactly when the request value of A or of B is nonzero. `fiq_o` is 1 exactly when the request value of F is nonzero. Both change in the cycle after the edge that updates status or mask.
- R8: A read at 0x04 returns `kbd_data`, and it clears bit KBD_BIT (default 7) of the group B status.
- R9: If a `set_b` pulse on bit KBD_BIT arrives in the same cycle as a read at 0x04, the status bit ends up set.
- R10: Counter n (0 to 3) in `cnt_val[16n+15:16n]` returns its low byte at offset 0x40+0x10·n and its high byte at 0x44+0x10·n.
- R11: A read at any other offset returns the byte 0xFF. A word read there is therefore all ones, and a byte read is 0x000000FF.
- R12: A write to any offset other than 0x00, 0x18, 0x28 and 0x38 changes no register. When no read is made, `bus_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = word read, 0 = byte read |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 32 | Write data; only bits 7:0 are used |
| bus_rdata | output | 32 | Registered read data |
| sclk_lvl | input | 1 | Serial-bus clock line level |
| sdat_lvl | input | 1 | Serial-bus data line level |
| kbd_data | input | 8 | Keyboard receive byte |
| set_a | input | 8 | Status set pulses, group A |
| set_b | input | 8 | Status set pulses, group B |
| set_f | input | 8 | Status set pulses, group F |
| cnt_val | input | 64 | Four packed 16-bit counter values, counter 0 in the low bits |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Two things can hit the keyboard-ready bit of group B in the same cycle: the read-clear caused by an access at 0x04, and a fresh set pulse from the receiver. The bench first reads the port once on its own and confirms that the bit drops. It then issues a second read at 0x04 in the same cycle as a `set_b` pulse on that bit. The outcome is judged by reading the group B status byte back over the bus, where the bit must still be set, and by the checker's property that any set pulse leaves the bit high on the next cycle.

// File: rtl/ioc_regbank.sv
module ioc_regbank #(
  parameter int AW      = 8,
  parameter int NCNT    = 4,
  parameter int KBD_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_word,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             sclk_lvl,
  input  logic             sdat_lvl,
  input  logic [7:0]       kbd_data,
  input  logic [7:0]       set_a,
  input  logic [7:0]       set_b,
  input  logic [7:0]       set_f,
  input  logic [16*NCNT-1:0] cnt_val,
  output logic             irq_o,
  output logic             fiq_o
);
  localparam logic [AW-1:0] OFS_CTL = AW'(8'h00);
  localparam logic [AW-1:0] OFS_KBD = AW'(8'h04);
  localparam logic [AW-1:0] OFS_SA  = AW'(8'h10);
  localparam logic [AW-1:0] OFS_RA  = AW'(8'h14);
  localparam logic [AW-1:0] OFS_MA  = AW'(8'h18);
  localparam logic [AW-1:0] OFS_SB  = AW'(8'h20);
  localparam logic [AW-1:0] OFS_RB  = AW'(8'h24);
  localparam logic [AW-1:0] OFS_MB  = AW'(8'h28);
  localparam logic [AW-1:0] OFS_SF  = AW'(8'h30);
  localparam logic [AW-1:0] OFS_RF  = AW'(8'h34);
  localparam logic [AW-1:0] OFS_MF  = AW'(8'h38);
  localparam int            CNT_BASE = 'h40;
  localparam logic [7:0]    KBD_MASK = 8'(1) << KBD_BIT;

  logic [7:0] ctl_q;
  logic [7:0] stat_a, stat_b, stat_f;
  logic [7:0] mask_a, mask_b, mask_f;
  logic [7:0] rd_byte;

  wire rd_en  = bus_sel & ~bus_wr;
  wire wr_en  = bus_sel &  bus_wr;
  wire kbd_rd = rd_en & (bus_addr == OFS_KBD);

  wire [7:0] req_a = stat_a & mask_a;
  wire [7:0] req_b = stat_b & mask_b;
  wire [7:0] req_f = stat_f & mask_f;
  wire [7:0] ctl_view = (ctl_q | 8'hC0) & ~{6'b0, sclk_lvl, sdat_lvl};

  wire unused_wdata = &{1'b0, bus_wdata[31:8]};

  assign irq_o = |{req_a, req_b};
  assign fiq_o = |req_f;

  always_comb begin
    rd_byte = 8'hFF;
    case (bus_addr)
      OFS_CTL: rd_byte = ctl_view;
      OFS_KBD: rd_byte = kbd_data;
      OFS_SA:  rd_byte = stat_a;
      OFS_RA:  rd_byte = req_a;
      OFS_MA:  rd_byte = mask_a;
      OFS_SB:  rd_byte = stat_b;
      OFS_RB:  rd_byte = req_b;
      OFS_MB:  rd_byte = mask_b;
      OFS_SF:  rd_byte = stat_f;
      OFS_RF:  rd_byte = req_f;
      OFS_MF:  rd_byte = mask_f;
      default: ;
    endcase
    for (int n = 0; n < NCNT; n++) begin
      if (bus_addr == AW'(CNT_BASE + 16 * n))
        rd_byte = cnt_val[16*n +: 8];
      if (bus_addr == AW'(CNT_BASE + 16 * n + 4))
        rd_byte = cnt_val[16*n+8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd_en) begin
      bus_rdata <= bus_word ? {8'hFF, rd_byte, 16'hFFFF} : {24'h0, rd_byte};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      mask_a <= '0;
      mask_b <= '0;
      mask_f <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        OFS_CTL: ctl_q  <= bus_wdata[7:0];
        OFS_MA:  mask_a <= bus_wdata[7:0];
        OFS_MB:  mask_b <= bus_wdata[7:0];
        OFS_MF:  mask_f <= bus_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_a <= '0;
      stat_b <= '0;
      stat_f <= '0;
    end else begin
      stat_a <= stat_a | set_a;
      stat_b <= (stat_b & ~(kbd_rd ? KBD_MASK : 8'h00)) | set_b;
      stat_f <= stat_f | set_f;
    end
  end
endmodule

module ioc_regbank_chk #(
  parameter int AW      = 8,
  parameter int KBD_BIT = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic          wr,
  input logic          word,
  input logic [AW-1:0] addr,
  input logic [7:0]    wbyte,
  input logic [31:0]   rdata,
  input logic [7:0]    setb,
  input logic [7:0]    statb,
  input logic [7:0]    maska,
  input logic [7:0]    maskb,
  input logic [7:0]    maskf,
  input logic          fiq
);
  // R2
  word_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && word) |=> (rdata[31:24] == 8'hFF && rdata[15:0] == 16'hFFFF));

  // R3
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && !word) |=> (rdata[31:8] == 24'h0));

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == AW'(8'h18)) |=> (maska == $past(wbyte)));

  // R7
  fiq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == AW'(8'h38) && wbyte == 8'h00) |=> !fiq);

  // R8
  kbd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && addr == AW'(8'h04) && !setb[KBD_BIT]) |=> !statb[KBD_BIT]);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setb[KBD_BIT] |=> statb[KBD_BIT]);

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && !wr) |=> $stable(rdata));

  // R12
  mask_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr && addr == AW'(8'h28)) |=> $stable(maskb));

  // R12
  mask_f_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr && addr == AW'(8'h38)) |=> $stable(maskf));
endmodule

bind ioc_regbank ioc_regbank_chk #(.AW(AW), .KBD_BIT(KBD_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .word(bus_word),
  .addr(bus_addr), .wbyte(bus_wdata[7:0]), .rdata(bus_rdata),
  .setb(set_b), .statb(stat_b), .maska(mask_a), .maskb(mask_b),
  .maskf(mask_f), .fiq(fiq_o)
);

// File: tb/sim_ioc_regbank.sv
module sim_ioc_regbank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0, bus_word = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        sclk_lvl = 1, sdat_lvl = 0;
  logic [7:0]  kbd_data = 8'h5A;
  logic [7:0]  set_a = 0, set_b = 0, set_f = 0;
  logic [63:0] cnt_val = {16'h8001, 16'h00FF, 16'hABCD, 16'h1234};
  logic        irq_o, fiq_o;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ioc_regbank u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sclk_lvl(sclk_lvl), .sdat_lvl(sdat_lvl),
    .kbd_data(kbd_data), .set_a(set_a), .set_b(set_b), .set_f(set_f),
    .cnt_val(cnt_val), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // {offset, word, expected}; setup: ctl=27, sclk=1 sdat=0, A=3C/0F, B=82/81, F=11/00
  localparam logic [40:0] VEC [23] = '{
    {8'h00, 1'b0, 32'h000000E5}, {8'h00, 1'b1, 32'hFFE5FFFF},
    {8'h10, 1'b0, 32'h0000003C}, {8'h10, 1'b1, 32'hFF3CFFFF},
    {8'h14, 1'b0, 32'h0000000C}, {8'h18, 1'b0, 32'h0000000F},
    {8'h20, 1'b0, 32'h00000082}, {8'h24, 1'b1, 32'hFF80FFFF},
    {8'h28, 1'b0, 32'h00000081}, {8'h30, 1'b0, 32'h00000011},
    {8'h34, 1'b0, 32'h00000000}, {8'h38, 1'b1, 32'hFF00FFFF},
    {8'h40, 1'b0, 32'h00000034}, {8'h44, 1'b0, 32'h00000012},
    {8'h50, 1'b1, 32'hFFCDFFFF}, {8'h54, 1'b0, 32'h000000AB},
    {8'h60, 1'b0, 32'h000000FF}, {8'h64, 1'b0, 32'h00000000},
    {8'h70, 1'b0, 32'h00000001}, {8'h74, 1'b1, 32'hFF80FFFF},
    {8'h0C, 1'b0, 32'h000000FF}, {8'h3C, 1'b1, 32'hFFFFFFFF},
    {8'h41, 1'b0, 32'h000000FF}
  };

  function automatic string tag_of(logic [7:0] a, logic w);
    string t;
    case (a)
      8'h00: t = "R4";
      8'h10, 8'h20, 8'h30: t = "R5";
      8'h14, 8'h18, 8'h24, 8'h28, 8'h34, 8'h38: t = "R6";
      8'h40, 8'h44, 8'h50, 8'h54, 8'h60, 8'h64, 8'h70, 8'h74: t = "R10";
      default: t = "R11";
    endcase
    return w ? {"R2/", t} : {"R3/", t};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, logic w, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_word = w; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", bus_rdata, 32'h0);
    check("R1 irq/fiq in reset", {30'h0, irq_o, fiq_o}, 32'h0);
    rst_n = 1;
    rd(8'h18, 1'b0, d); check("R1 mask A after reset", d, 32'h0);
    rd(8'h20, 1'b0, d); check("R1 status B after reset", d, 32'h0);

    wr(8'h00, 32'hFFFF_FF27);
    wr(8'h18, 32'h0000_000F);
    wr(8'h28, 32'h0000_0081);
    wr(8'h38, 32'h0000_0000);
    @(negedge clk);
    set_a = 8'h3C; set_b = 8'h82; set_f = 8'h11;
    @(negedge clk);
    set_a = 0; set_b = 0; set_f = 0;
    check("R7 irq from A/B request", {31'h0, irq_o}, 32'h1);
    check("R7 fiq masked off", {31'h0, fiq_o}, 32'h0);

    for (int i = 0; i < 23; i++) begin
      rd(VEC[i][40:33], VEC[i][32], d);
      check(tag_of(VEC[i][40:33], VEC[i][32]), d, VEC[i][31:0]);
    end

    // R12 rdata holds while idle
    repeat (3) @(negedge clk);
    check("R12 rdata hold", bus_rdata, 32'h000000FF);

    // R8 keyboard read returns byte and clears B bit 7
    rd(8'h04, 1'b0, d); check("R8 kbd data", d, 32'h0000005A);
    rd(8'h20, 1'b0, d); check("R8 B status after kbd read", d, 32'h00000002);
    rd(8'h04, 1'b1, d); check("R2 kbd word read", d, 32'hFF5AFFFF);

    // R9 set pulse wins over read-clear
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_word = 0; bus_addr = 8'h04; set_b = 8'h80;
    @(negedge clk);
    bus_sel = 0; set_b = 0;
    rd(8'h20, 1'b0, d); check("R9 set beats clear", d, 32'h00000082);

    // R4 other line levels
    sclk_lvl = 0; sdat_lvl = 1;
    rd(8'h00, 1'b0, d); check("R4 data line high", d, 32'h000000E6);
    sclk_lvl = 0; sdat_lvl = 0;
    rd(8'h00, 1'b0, d); check("R4 both lines low", d, 32'h000000E7);

    // R12 writes to non-writable offsets ignored
    wr(8'h10, 32'h0000_00FF);
    wr(8'h14, 32'h0000_00FF);
    rd(8'h10, 1'b0, d); check("R12 status A unchanged", d, 32'h0000003C);
    rd(8'h18, 1'b0, d); check("R12 mask A unchanged", d, 32'h0000000F);

    // R7 output follows masks
    wr(8'h18, 32'h0);
    check("R7 irq held by B", {31'h0, irq_o}, 32'h1);
    wr(8'h28, 32'h0);
    check("R7 irq drops", {31'h0, irq_o}, 32'h0);
    wr(8'h38, 32'h0000_0001);
    check("R7 fiq rises", {31'h0, fiq_o}, 32'h1);
    rd(8'h34, 1'b0, d); check("R6 F request", d, 32'h00000001);

    // R5 status sticky, new pulse accumulates
    @(negedge clk); set_f = 8'h40; @(negedge clk); set_f = 0;
    rd(8'h30, 1'b0, d); check("R5 F status accumulates", d, 32'h00000051);

    // R1 reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check("R1 irq/fiq after reset", {30'h0, irq_o, fiq_o}, 32'h0);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    rst_n = 1;
    rd(8'h38, 1'b0, d); check("R1 mask F cleared", d, 32'h0);
    rd(8'h30, 1'b0, d); check("R1 status F cleared", d, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule